// File: doc/BRIEF.md
# Serial Identity Register Slave

This block is a two-wire serial slave (I2C/SMBus compatible) that gives a chip a fixed identity that a host can read. It holds a nine-location byte map. Locations 00h to 07h return a 64-bit identity value that is set by a parameter and cannot be changed. Location 08h is a single control register that the host can both write and read. The block samples SCL and SDA with its own system clock. From those samples it finds START, repeated START and STOP conditions. It drives SDA only through an open-drain enable.

A host sets the location pointer by addressing the block for writing and sending one pointer byte. It then either sends data bytes or issues a repeated START and reads. The pointer advances after each complete data byte and wraps from 08h to 00h. This holds when the host reads and when it writes. Writes to the identity locations are refused with a NACK, but the pointer still advances past them. An optional timeout returns the serial interface to idle when SCL is held low too long. The timeout does not touch the pointer or the control register.

Top module: `serial_id_slave`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR is acknowledged whatever its direction bit (bit 0: 0 = write, 1 = read). Any other address is not acknowledged, and the block leaves SDA released until the next START.
- R2: In a write access, the first byte after the address is the pointer byte. Values 00h to 08h are acknowledged and loaded into the pointer. A larger value is not acknowledged and leaves the pointer unchanged. Every later data byte in that same access is then not acknowledged and is discarded.
- R3: A data byte written while the pointer is 08h is stored in the control register and acknowledged. A data byte written while the pointer is 00h to 07h is discarded and not acknowledged, so SDA stays high in its acknowledge slot.
- R4: The pointer advances by one after every complete data byte the host writes, including refused ones. The pointer always stays within 00h to 08h, and after a byte at 08h it becomes 00h.
- R5: A read access starts at the current pointer and sends each byte MSB first. Location i (0 to 7) returns bits [8i+7:8i] of ID_VALUE, and location 08h returns the control register. The pointer advances after each byte sent and wraps from 08h to 00h.
- R6: When the host does not acknowledge a byte it has read, the block releases SDA and does not drive it again until a new START.
- R7: After reset the pointer is 00h, the control register holds CTRL_INIT, and SDA is released.
- R8: A repeated START, in any state, returns the block to receiving an address byte, with SDA released.
- R9: A STOP returns the block to idle with SDA released.
- R10: When TIMEOUT_EN is set and synchronised SCL stays low for TIMEOUT_CYCLES system clocks during a transfer, the block goes idle and releases SDA. The pointer and the control register keep their values.
- R11: The SDA drive enable (1 = pull SDA low) changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock level seen on the bus |
| sda_in | input | 1 | Serial data level seen on the bus |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The assertions assume that each SCL level lasts well beyond the synchroniser delay. They also assume that SDA moves while SCL is high only to form a START or STOP, and that the host never forms a START or STOP while the slave holds SDA low. The bench drives SCL with a quarter period of ten system clocks and changes SDA only in the middle of the SCL low phase. It models the wired-AND bus by combining its own drive with the block's enable. A single long SCL-low hold is used to trigger the timeout on purpose. Every other low phase stays far below TIMEOUT_CYCLES.

// File: rtl/sid_pkg.sv
package sid_pkg;

  // Highest location of the byte map; locations below it are identity bytes.
  localparam int MAP_LAST = 8;
  localparam int PW       = 4;

  typedef logic [PW-1:0] ptr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_MACK,
    ST_WAIT
  } st_t;

  // Next pointer value: wraps from the top location back to zero.
  function automatic ptr_t ptr_next(input ptr_t p);
    return (p == ptr_t'(MAP_LAST)) ? '0 : p + 1'b1;
  endfunction

  // Pointer byte legality.
  function automatic logic ptr_byte_ok(input logic [7:0] b);
    return b <= 8'(MAP_LAST);
  endfunction

  // True at the writable control location.
  function automatic logic is_ctrl(input ptr_t p);
    return p == ptr_t'(MAP_LAST);
  endfunction

endpackage

// File: rtl/sid_sync.sv
module sid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_p;
  logic              sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;

endmodule

// File: rtl/sid_timeout.sv
module sid_timeout #(
  parameter bit ENABLE = 1'b1,
  parameter int LIMIT  = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic busy,
  output logic tmo_ev
);

  generate
    if (ENABLE) begin : g_on
      localparam int CW = $clog2(LIMIT + 1);
      logic [CW-1:0] low_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          low_cnt <= '0;
        end else if (!busy || scl_s) begin
          low_cnt <= '0;
        end else if (low_cnt != CW'(LIMIT)) begin
          low_cnt <= low_cnt + 1'b1;
        end
      end

      assign tmo_ev = busy && !scl_s && (low_cnt == CW'(LIMIT - 1));
    end else begin : g_off
      logic unused_tmo;
      assign unused_tmo = ^{clk, rst_n, scl_s, busy};
      assign tmo_ev     = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/sid_regfile.sv
module sid_regfile
  import sid_pkg::*;
#(
  parameter int                       ROM_BYTES = MAP_LAST,
  parameter logic [8*ROM_BYTES-1:0]   ID_VALUE  = '0,
  parameter logic [7:0]               CTRL_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ptr_load,
  input  ptr_t       ptr_wdata,
  input  logic       ptr_inc,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  output ptr_t       ptr,
  output logic [7:0] rd_data,
  output logic [7:0] ctrl_q
);

  localparam int RW = $clog2(ROM_BYTES);

  logic [7:0] rom [ROM_BYTES];

  for (genvar g = 0; g < ROM_BYTES; g++) begin : g_rom
    assign rom[g] = ID_VALUE[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_load) begin
      ptr <= ptr_wdata;
    end else if (ptr_inc) begin
      ptr <= ptr_next(ptr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_wdata;
    end
  end

  assign rd_data = is_ctrl(ptr) ? ctrl_q : rom[ptr[RW-1:0]];

endmodule

// File: rtl/sid_fsm.sv
module sid_fsm
  import sid_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       tmo_ev,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  ptr_t       ptr,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       busy,
  output logic       ptr_load,
  output ptr_t       ptr_wdata,
  output logic       ptr_inc,
  output logic       ctrl_we,
  output logic [7:0] ctrl_wdata,
  output logic       wdata_done
);

  st_t        state;
  st_t        after_ack;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [7:0] tx;
  logic       ptr_ok;
  logic       mack_q;

  logic quiet;
  logic rx_state;
  logic byte_done;
  logic tx_done;
  logic addr_hit;
  logic load_next;

  assign quiet     = !(start_ev || stop_ev || tmo_ev);
  assign rx_state  = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);
  assign byte_done = quiet && rx_state && scl_fall && (bit_cnt == 4'd8);
  assign tx_done   = quiet && (state == ST_RDATA) && scl_fall && (bit_cnt == 4'd8);
  assign addr_hit  = (shreg[7:1] == DEV_ADDR);
  assign load_next = quiet && scl_fall &&
                     (((state == ST_ACK) && (after_ack == ST_RDATA)) ||
                      ((state == ST_MACK) && mack_q));

  // Strobes towards the register file.
  assign ptr_load   = byte_done && (state == ST_PTR) && ptr_byte_ok(shreg);
  assign ptr_wdata  = shreg[PW-1:0];
  assign wdata_done = byte_done && (state == ST_WDATA);
  assign ctrl_we    = wdata_done && ptr_ok && is_ctrl(ptr);
  assign ctrl_wdata = shreg;
  assign ptr_inc    = (wdata_done && ptr_ok) || tx_done;
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      tx        <= '0;
      ptr_ok    <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (start_ev) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_ev || tmo_ev) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (load_next) begin
      tx      <= rd_data;
      sda_oe  <= ~rd_data[7];
      bit_cnt <= '0;
      state   <= ST_RDATA;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              if (addr_hit) begin
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                after_ack <= shreg[0] ? ST_RDATA : ST_PTR;
              end else begin
                state <= ST_WAIT;
              end
            end else if (state == ST_PTR) begin
              ptr_ok    <= ptr_byte_ok(shreg);
              sda_oe    <= ptr_byte_ok(shreg);
              state     <= ST_ACK;
              after_ack <= ST_WDATA;
            end else begin
              sda_oe    <= ptr_ok && is_ctrl(ptr);
              state     <= ST_ACK;
              after_ack <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= after_ack;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (tx_done) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_MACK;
          end else if (scl_fall) begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            state <= ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/serial_id_slave.sv
module serial_id_slave
  import sid_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR       = 7'h50,
  parameter logic [63:0] ID_VALUE       = 64'h0F1E_2D3C_4B5A_6978,
  parameter logic [7:0]  CTRL_INIT      = 8'h00,
  parameter int          SYNC_STAGES    = 2,
  parameter bit          TIMEOUT_EN     = 1'b1,
  parameter int          TIMEOUT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);

  logic       scl_s;
  logic       sda_s;
  logic       start_ev;
  logic       stop_ev;
  logic       scl_rise;
  logic       scl_fall;
  logic       tmo_ev;
  logic       busy;
  logic       ptr_load;
  ptr_t       ptr_wdata;
  logic       ptr_inc;
  logic       ctrl_we;
  logic [7:0] ctrl_wdata;
  logic       wdata_done;
  ptr_t       ptr;
  logic [7:0] rd_data;
  logic [7:0] ctrl_q;

  sid_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  sid_timeout #(.ENABLE(TIMEOUT_EN), .LIMIT(TIMEOUT_CYCLES)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_s  (scl_s),
    .busy   (busy),
    .tmo_ev (tmo_ev)
  );

  sid_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .tmo_ev     (tmo_ev),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .ptr        (ptr),
    .rd_data    (rd_data),
    .sda_oe     (sda_oe),
    .busy       (busy),
    .ptr_load   (ptr_load),
    .ptr_wdata  (ptr_wdata),
    .ptr_inc    (ptr_inc),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .wdata_done (wdata_done)
  );

  sid_regfile #(
    .ROM_BYTES (MAP_LAST),
    .ID_VALUE  (ID_VALUE),
    .CTRL_INIT (CTRL_INIT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_load   (ptr_load),
    .ptr_wdata  (ptr_wdata),
    .ptr_inc    (ptr_inc),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ptr        (ptr),
    .rd_data    (rd_data),
    .ctrl_q     (ctrl_q)
  );

endmodule

// File: rtl/sid_checker.sv
module sid_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       tmo_ev,
  input logic       sda_oe,
  input logic [3:0] ptr,
  input logic [7:0] ctrl_q,
  input logic       wdata_done
);

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s)); // R11

  AST_STOP_FREES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe); // R9

  AST_START_FREES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe); // R8

  AST_PTR_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= 4'd8); // R4

  AST_TMO_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_ev |=> (ptr == $past(ptr)) && !sda_oe); // R10

  AST_ROM_WRITE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_done && (ptr != 4'd8)) |=> !sda_oe); // R3

  AST_CTRL_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> ($past(wdata_done) && ($past(ptr) == 4'd8))); // R3

endmodule

bind serial_id_slave sid_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .start_ev   (start_ev),
  .stop_ev    (stop_ev),
  .tmo_ev     (tmo_ev),
  .sda_oe     (sda_oe),
  .ptr        (ptr),
  .ctrl_q     (ctrl_q),
  .wdata_done (wdata_done)
);

// File: tb/serial_id_slave_test.sv
`timescale 1ns/1ps
module serial_id_slave_test;

  localparam logic [6:0]  DEV   = 7'h5A;
  localparam logic [63:0] ID    = 64'h1E2D_3C4B_5A69_7887;
  localparam logic [7:0]  CINIT = 8'hC3;
  localparam int          TMO   = 600;
  localparam int          Q     = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } item_t;

  item_t exp_q[$];
  item_t obs_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  serial_id_slave #(
    .DEV_ADDR       (DEV),
    .ID_VALUE       (ID),
    .CTRL_INIT      (CINIT),
    .SYNC_STAGES    (2),
    .TIMEOUT_EN     (1'b1),
    .TIMEOUT_CYCLES (TMO)
  ) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (scl_m),
    .sda_in (sda_bus),
    .sda_oe (sda_oe)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] idb(input int i);
    return ID[8*i +: 8];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, output logic s);
    sda_m = b;
    tick(Q);
    scl_m = 1'b1;
    tick(Q);
    s = sda_bus;
    tick(Q);
    scl_m = 1'b0;
    tick(Q);
  endtask

  task automatic start_c();
    sda_m = 1'b1;
    tick(Q);
    scl_m = 1'b1;
    tick(Q);
    sda_m = 1'b0;
    tick(Q);
    scl_m = 1'b0;
    tick(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0;
    tick(Q);
    scl_m = 1'b1;
    tick(Q);
    sda_m = 1'b1;
    tick(Q);
  endtask

  // Driver: expected slot value (0 = acknowledged) goes in before the observation.
  task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    exp_q.push_back('{{7'd0, !exp_ack}, tag});
    bit_cycle(1'b1, s);
    obs_q.push_back('{{7'd0, s}, tag});
  endtask

  task automatic rd_byte(input logic [7:0] e, input logic m_ack, input string tag);
    logic [7:0] d;
    logic       s;
    exp_q.push_back('{e, tag});
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      d[i] = s;
    end
    obs_q.push_back('{d, tag});
    bit_cycle(!m_ack, s);
  endtask

  task automatic direct(input logic [7:0] act, input logic [7:0] e, input string tag);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, e);
    end
  endtask

  // Monitor: pops the scoreboard and compares.
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        item_t o;
        item_t e;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        checks++;
        if (o.v !== e.v) begin
          fails++;
          $display("FAIL %s: actual %02h expected %02h", e.tag, o.v, e.v);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] extra;
    logic       s;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    direct({7'd0, sda_oe}, 8'h00, "R7 SDA released after reset");

    // A: read from reset pointer across the wrap, then ignored bits after NACK.
    start_c();
    wr_byte({DEV, 1'b1}, 1'b1, "R1 read address acknowledged");
    for (int i = 0; i < 10; i++) begin
      if (i % 9 == 8) rd_byte(CINIT, 1'b1, "R7 control reset value");
      else            rd_byte(idb(i % 9), (i != 9), "R5 identity byte in order and wrap");
    end
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      extra[i] = s;
    end
    exp_q.push_back('{8'hFF, "R6 no drive after host NACK"});
    obs_q.push_back('{extra, "R6 no drive after host NACK"});
    stop_c();

    // B: control write, refused identity write, then read back.
    start_c();
    wr_byte({DEV, 1'b0}, 1'b1, "R1 write address acknowledged");
    wr_byte(8'h08, 1'b1, "R2 pointer 08h acknowledged");
    wr_byte(8'h3C, 1'b1, "R3 control write acknowledged");
    wr_byte(8'h77, 1'b0, "R3 identity write refused");
    stop_c();
    start_c();
    wr_byte({DEV, 1'b1}, 1'b1, "R1 read address acknowledged");
    for (int i = 1; i <= 7; i++) rd_byte(idb(i), 1'b1, "R4 pointer advanced past refused write");
    rd_byte(8'h3C, 1'b0, "R3 control holds written value");
    stop_c();

    // C: repeated START read, then an illegal pointer.
    start_c();
    wr_byte({DEV, 1'b0}, 1'b1, "R1 write address acknowledged");
    wr_byte(8'h05, 1'b1, "R2 pointer 05h acknowledged");
    start_c();
    wr_byte({DEV, 1'b1}, 1'b1, "R8 address after repeated START");
    rd_byte(idb(5), 1'b0, "R8 read at loaded pointer");
    stop_c();
    start_c();
    wr_byte({DEV, 1'b0}, 1'b1, "R1 write address acknowledged");
    wr_byte(8'h0C, 1'b0, "R2 pointer above 08h refused");
    wr_byte(8'h55, 1'b0, "R2 data after refused pointer refused");
    stop_c();
    start_c();
    wr_byte({DEV, 1'b1}, 1'b1, "R1 read address acknowledged");
    rd_byte(idb(6), 1'b1, "R2 pointer unchanged by refused pointer");
    rd_byte(idb(7), 1'b1, "R5 sequential read");
    rd_byte(8'h3C, 1'b0, "R2 data after refused pointer discarded");
    stop_c();

    // D: write sequence across the wrap.
    start_c();
    wr_byte({DEV, 1'b0}, 1'b1, "R1 write address acknowledged");
    wr_byte(8'h07, 1'b1, "R2 pointer 07h acknowledged");
    wr_byte(8'h11, 1'b0, "R3 identity write refused");
    wr_byte(8'hA5, 1'b1, "R3 control write acknowledged");
    wr_byte(8'h22, 1'b0, "R4 write after wrap lands on 00h");
    stop_c();
    start_c();
    wr_byte({DEV, 1'b1}, 1'b1, "R1 read address acknowledged");
    rd_byte(idb(1), 1'b0, "R4 write pointer wrapped and advanced");
    stop_c();
    start_c();
    wr_byte({DEV, 1'b0}, 1'b1, "R1 write address acknowledged");
    wr_byte(8'h08, 1'b1, "R2 pointer 08h acknowledged");
    start_c();
    wr_byte({DEV, 1'b1}, 1'b1, "R8 address after repeated START");
    rd_byte(8'hA5, 1'b0, "R3 control holds second write");
    stop_c();

    // E: foreign address.
    start_c();
    wr_byte({7'h33, 1'b0}, 1'b0, "R1 foreign address refused");
    wr_byte(8'h08, 1'b0, "R1 bytes after foreign address ignored");
    stop_c();

    // F: timeout in the middle of a read.
    start_c();
    wr_byte({DEV, 1'b0}, 1'b1, "R1 write address acknowledged");
    wr_byte(8'h01, 1'b1, "R2 pointer 01h acknowledged");
    stop_c();
    start_c();
    wr_byte({DEV, 1'b1}, 1'b1, "R1 read address acknowledged");
    tick(2);
    direct({7'd0, sda_oe}, 8'h01, "R10 slave driving before timeout");
    tick(TMO + 50);
    direct({7'd0, sda_oe}, 8'h00, "R10 SDA released by timeout");
    stop_c();
    start_c();
    wr_byte({DEV, 1'b1}, 1'b1, "R1 read address acknowledged");
    rd_byte(idb(1), 1'b1, "R10 pointer kept across timeout");
    rd_byte(idb(2), 1'b0, "R5 sequential read");
    stop_c();

    tick(10);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule